// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a down-counting timer that sits on a simple 32-bit register bus and raises an interrupt request that carries an 8-bit vector chosen by software. Software sets up a control word, a clock divider and a start value. Writing the start value loads the counter and starts it. The counter then steps down once per divided clock tick. When it runs out, the timer signals an interrupt unless the interrupt is masked.

In one-shot mode the counter stops at zero after its single expiry. In periodic mode it reloads from the start value each time it expires, so interrupts arrive at a fixed rate that the divider scales. A read-only register returns the live count. A busy flag in the control word shows that an interrupt is waiting to be taken. The flag clears once the receiver signals that it has taken the interrupt.

Top module: `cpu_local_timer`

## Requirements
- R1: Registers sit at byte offsets 0x320 (control), 0x380 (start count), 0x390 (live count) and 0x3E0 (divider). After reset the control register reads 0x0001_0000 (masked, one-shot, vector 0, idle), and the start count, live count and divider all read zero. irq_valid_o and irq_busy_o are low after reset.
- R2: A write to the start count loads the counter with the written value and starts it. The live count register returns the counter value in the same cycle it is read. A start value of zero stops the timer, and no interrupt follows.
- R3: The divider code is formed from divider bits {3,1,0}. Codes 000 to 110 divide the clock by 2, 4, 8, 16, 32, 64 and 128, and code 111 divides by 1. Writing the start count or the divider restarts the prescaler. With division D and start value N, the counter expires on the D*N-th rising edge after the edge that wrote the start count.
- R4: In one-shot mode (control bit 17 = 0) exactly one interrupt is raised. After it the counter stays at zero.
- R5: In periodic mode (control bit 17 = 1) the counter reloads from the start count on every expiry, and interrupts repeat every D*N cycles.
- R6: With control bit 16 set, expiries raise no interrupt and do not set busy. The counter still runs.
- R7: An unmasked expiry drives irq_valid_o high for exactly one cycle, in the cycle that follows the expiry edge. irq_vector_o then equals control bits 7:0.
- R8: Busy (control bit 12, also on irq_busy_o) is set with each interrupt. It clears on the first edge at which irq_ready_i is high. If a new interrupt arrives on that same edge, busy stays set.
- R9: The live count register ignores writes. Unused bits of every register read as zero and ignore writes. The busy bit cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_vector_o | output | 8 | Vector sent with the request |
| irq_ready_i | input | 1 | Receiver has taken the pending interrupt |
| irq_busy_o | output | 1 | Interrupt pending delivery |

## Verification
Two events can land on the same clock edge: an expiry sets the busy flag, and irq_ready_i clears it. To force this, the bench uses periodic mode with a start count of one and a divide-by-1 setting, so the counter expires on every edge, while irq_ready_i is held high. On every sampled cycle the bench then expects irq_valid_o and irq_busy_o to be high together. A design in which the clear overrides the set shows busy low between interrupts. The bench also checks that a write to the live count register, made while the counter runs, leaves the count sequence unchanged.

// File: rtl/cpu_local_timer_pkg.sv
package cpu_local_timer_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h320;
  localparam logic [ADDR_W-1:0] OFF_START = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_LIVE  = 12'h390;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 12'h3E0;

  localparam int CTRL_BUSY_BIT = 12;
  localparam int CTRL_MASK_BIT = 16;
  localparam int CTRL_MODE_BIT = 17;
  localparam int DIV_HI_BIT    = 3;
  localparam int DIV_CODE_W    = 3;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e  mode;
    logic       mask;
    logic [7:0] vec;
  } ctrl_t;
endpackage

// File: rtl/lt_regfile.sv
module lt_regfile
  import cpu_local_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [CNT_W-1:0]      live_i,
  input  logic                  busy_i,
  output ctrl_t                 ctrl_o,
  output logic [CNT_W-1:0]      start_o,
  output logic [DIV_CODE_W-1:0] div_code_o,
  output logic                  load_o,
  output logic                  div_wr_o,
  output logic [DATA_W-1:0]     rdata_o
);
  ctrl_t                 ctrl_q;
  logic [CNT_W-1:0]      start_q;
  logic [DIV_CODE_W-1:0] div_q;
  logic                  ctrl_wr;

  assign ctrl_wr  = wr_i && (addr_i == OFF_CTRL);
  assign load_o   = wr_i && (addr_i == OFF_START);
  assign div_wr_o = wr_i && (addr_i == OFF_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.vec  <= '0;
      ctrl_q.mask <= 1'b1;
      ctrl_q.mode <= MODE_ONESHOT;
      start_q     <= '0;
      div_q       <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.vec  <= wdata_i[7:0];
        ctrl_q.mask <= wdata_i[CTRL_MASK_BIT];
        ctrl_q.mode <= tmr_mode_e'(wdata_i[CTRL_MODE_BIT]);
      end
      if (load_o)   start_q <= wdata_i[CNT_W-1:0];
      if (div_wr_o) div_q   <= {wdata_i[DIV_HI_BIT], wdata_i[1:0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: begin
        rdata_o[7:0]          = ctrl_q.vec;
        rdata_o[CTRL_BUSY_BIT] = busy_i;
        rdata_o[CTRL_MASK_BIT] = ctrl_q.mask;
        rdata_o[CTRL_MODE_BIT] = ctrl_q.mode;
      end
      OFF_START: rdata_o[CNT_W-1:0] = start_q;
      OFF_LIVE:  rdata_o[CNT_W-1:0] = live_i;
      OFF_DIV: begin
        rdata_o[DIV_HI_BIT] = div_q[2];
        rdata_o[1:0]        = div_q[1:0];
      end
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign start_o    = start_q;
  assign div_code_o = div_q;
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int NUM_DIV = (1 << CODE_W) - 1;   // last code means divide-by-1
  localparam logic [CODE_W-1:0] CODE_BYPASS = CODE_W'(NUM_DIV);

  logic [NUM_DIV-1:0] presc_q;
  logic [NUM_DIV-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     presc_q <= '0;
    else if (clr_i)  presc_q <= '0;
    else             presc_q <= presc_q + NUM_DIV'(1);
  end

  // code g divides by 2**(g+1): tick when low g+1 bits are all ones
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_hit
    assign hit[g] = &presc_q[g:0];
  end

  assign tick_o = (code_i == CODE_BYPASS) ? 1'b1 : hit[code_i];
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // load overrides a coincident tick
  assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (expire_o)                cnt_q <= periodic_i ? reload_val_i : '0;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lt_irq.sv
module lt_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       mask_i,
  input  logic [7:0] vec_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] vector_o,
  output logic       busy_o
);
  logic       fire;
  logic       valid_q, busy_q;
  logic [7:0] vector_q;

  assign fire = expire_i && !mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      busy_q   <= 1'b0;
      vector_q <= '0;
    end else begin
      valid_q <= fire;
      if (fire) vector_q <= vec_i;
      if (fire)                 busy_q <= 1'b1;  // new request beats the clear
      else if (ready_i && busy_q) busy_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign vector_o = vector_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/cpu_local_timer.sv
module cpu_local_timer
  import cpu_local_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [11:0]       bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_valid_o,
  output logic [7:0]        irq_vector_o,
  input  logic              irq_ready_i,
  output logic              irq_busy_o
);
  ctrl_t                 ctrl_q;
  logic [CNT_W-1:0]      start_q;
  logic [CNT_W-1:0]      cur_q;
  logic [DIV_CODE_W-1:0] div_code;
  logic                  load, div_wr, tick, expire, busy;

  lt_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .live_i     (cur_q),
    .busy_i     (busy),
    .ctrl_o     (ctrl_q),
    .start_o    (start_q),
    .div_code_o (div_code),
    .load_o     (load),
    .div_wr_o   (div_wr),
    .rdata_o    (bus_rdata_o)
  );

  lt_prescaler #(.CODE_W(DIV_CODE_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load || div_wr),
    .code_i (div_code),
    .tick_o (tick)
  );

  lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .load_val_i   (bus_wdata_i[CNT_W-1:0]),
    .reload_val_i (start_q),
    .tick_i       (tick),
    .periodic_i   (ctrl_q.mode == MODE_PERIODIC),
    .cnt_o        (cur_q),
    .expire_o     (expire)
  );

  lt_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .mask_i   (ctrl_q.mask),
    .vec_i    (ctrl_q.vec),
    .ready_i  (irq_ready_i),
    .valid_o  (irq_valid_o),
    .vector_o (irq_vector_o),
    .busy_o   (busy)
  );

  assign irq_busy_o = busy;
endmodule

// File: rtl/cpu_local_timer_chk.sv
module cpu_local_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_valid_i,
  input logic [7:0]       irq_vector_i,
  input logic             irq_busy_i,
  input logic             irq_ready_i,
  input logic             mask_i,
  input logic             periodic_i,
  input logic [7:0]       vec_i,
  input logic [CNT_W-1:0] cur_i,
  input logic [CNT_W-1:0] start_i,
  input logic             load_i
);
  // R6: no request when the mask was set on the expiry edge
  assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i |-> !$past(mask_i));

  // R7: vector matches the control word sampled at expiry
  assert_vector_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i |-> irq_vector_i == $past(vec_i));

  // R8: busy rises only together with a request
  assert_busy_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_busy_i) |-> irq_valid_i);

  // R8: busy falls only after ready was seen
  assert_busy_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_busy_i) |-> $past(irq_ready_i));

  // R4: an idle one-shot counter stays at zero without a new start
  assert_oneshot_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i == '0 && !load_i && !periodic_i) |=> cur_i == '0);

  // R2, R5: a running counter holds, steps down by one, or reloads
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i != '0 && !load_i) |=>
      (cur_i == $past(cur_i) || cur_i == $past(cur_i) - CNT_W'(1) || cur_i == $past(start_i)));
endmodule

bind cpu_local_timer cpu_local_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_valid_i  (irq_valid_o),
  .irq_vector_i (irq_vector_o),
  .irq_busy_i   (irq_busy_o),
  .irq_ready_i  (irq_ready_i),
  .mask_i       (ctrl_q.mask),
  .periodic_i   (ctrl_q.mode == cpu_local_timer_pkg::MODE_PERIODIC),
  .vec_i        (ctrl_q.vec),
  .cur_i        (cur_q),
  .start_i      (start_q),
  .load_i       (load)
);

// File: tb/sim_cpu_local_timer.sv
module sim_cpu_local_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h320, A_START = 12'h380, A_LIVE = 12'h390, A_DIV = 12'h3E0;

  typedef struct packed {
    logic [3:0]  dcr;
    logic        periodic;
    logic [7:0]  vec;
    logic [15:0] start;
    logic [15:0] cycles;   // D*N per R3
  } tv_t;

  localparam int NTV = 6;
  localparam tv_t TV [NTV] = '{
    '{4'b1011, 1'b0, 8'h31, 16'd5, 16'd5},    // div 1
    '{4'b0000, 1'b1, 8'h40, 16'd3, 16'd6},    // div 2
    '{4'b0001, 1'b0, 8'h22, 16'd4, 16'd16},   // div 4
    '{4'b1010, 1'b1, 8'h9A, 16'd2, 16'd256},  // div 128
    '{4'b1000, 1'b0, 8'hC3, 16'd3, 16'd96},   // div 32
    '{4'b0011, 1'b1, 8'h07, 16'd1, 16'd16}    // div 16
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_valid, irq_busy;
  logic [7:0]  irq_vec;
  logic        ready = 1'b1;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_local_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_valid_o(irq_valid),
    .irq_vector_o(irq_vec), .irq_ready_i(ready), .irq_busy_o(irq_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (!irq_valid && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, r);  chk("R1 ctrl reset", r, 32'h0001_0000);
    bus_read(A_START, r); chk("R1 start reset", r, 0);
    bus_read(A_LIVE, r);  chk("R1 live reset", r, 0);
    bus_read(A_DIV, r);   chk("R1 div reset", r, 0);
    chk("R1 irq idle", {irq_valid, irq_busy}, 0);

    // table walk: R3 R4 R5 R7 R8
    for (int i = 0; i < NTV; i++) begin
      bus_write(A_START, 0);
      bus_write(A_DIV, {28'd0, TV[i].dcr});
      bus_write(A_CTRL, {14'd0, TV[i].periodic, 1'b0, 8'd0, TV[i].vec});
      bus_write(A_START, {16'd0, TV[i].start});
      wait_irq(1000, n);
      chk($sformatf("R3 interval entry %0d", i), n, TV[i].cycles);
      chk("R7 vector", irq_vec, TV[i].vec);
      chk("R8 busy set", irq_busy, 1);
      @(negedge clk);
      chk("R7 single pulse", irq_valid, 0);
      chk("R8 busy cleared by ready", irq_busy, 0);
      if (TV[i].periodic) begin
        n = 1;
        while (!irq_valid && n < 1000) begin @(negedge clk); n++; end
        chk("R5 periodic repeat", n, TV[i].cycles);
      end else begin
        seen = 0;
        for (int k = 0; k < 2 * TV[i].cycles; k++) begin
          @(negedge clk); seen |= irq_valid;
        end
        chk("R4 no second irq", seen, 0);
        bus_read(A_LIVE, r); chk("R4 stays zero", r, 0);
      end
    end

    // R2 live count and stop
    bus_write(A_START, 0);
    bus_write(A_DIV, 32'hB);
    bus_write(A_CTRL, 32'h0000_0011);
    bus_write(A_START, 10);
    bus_read(A_LIVE, r); chk("R2 loaded", r, 10);
    @(negedge clk);
    bus_read(A_LIVE, r); chk("R2 step", r, 9);
    repeat (3) @(negedge clk);
    bus_read(A_LIVE, r); chk("R2 live", r, 6);
    bus_read(A_START, r); chk("R2 start readback", r, 10);
    bus_write(A_START, 0);
    bus_read(A_LIVE, r); chk("R2 stopped", r, 0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); seen |= irq_valid; end
    chk("R2 no irq after stop", seen, 0);

    // R6 mask
    bus_write(A_CTRL, 32'h0001_0055);
    bus_write(A_START, 3);
    seen = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); seen |= irq_valid | irq_busy; end
    chk("R6 masked quiet", seen, 0);
    bus_read(A_LIVE, r); chk("R6 counter ran", r, 0);

    // R8 busy held until ready
    ready = 1'b0;
    bus_write(A_CTRL, 32'h0000_0077);
    bus_write(A_START, 2);
    wait_irq(100, n);
    chk("R8 irq seen", irq_valid, 1);
    repeat (5) @(negedge clk);
    chk("R8 busy held", irq_busy, 1);
    bus_read(A_CTRL, r); chk("R8 busy bit in ctrl", r, 32'h0000_1077);
    ready = 1'b1;
    @(negedge clk);
    chk("R8 busy cleared", irq_busy, 0);

    // R8 expiry and ready on the same edge
    bus_write(A_CTRL, 32'h0002_0012);
    bus_write(A_START, 1);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); seen |= !(irq_valid && irq_busy);
    end
    chk("R8 set beats clear", seen, 0);
    bus_write(A_START, 0);

    // R9 read-only and reserved bits
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    bus_read(A_CTRL, r); chk("R9 ctrl reserved", r, 32'h0003_00FF);
    bus_write(A_DIV, 32'hFFFF_FFFF);
    bus_read(A_DIV, r); chk("R9 div reserved", r, 32'h0000_000B);
    bus_write(A_LIVE, 32'h1234);
    bus_read(A_LIVE, r); chk("R9 live write ignored idle", r, 0);
    bus_write(A_CTRL, 32'h0001_0000);
    bus_write(A_START, 50);
    bus_write(A_LIVE, 32'hFFFF);
    bus_read(A_LIVE, r); chk("R9 live write ignored running", r, 48);
    bus_write(A_START, 0);

    finish_run();
  end
endmodule